// File: doc/BRIEF.md
# Fuse Shadow Cache Loader

This block gathers the fuse rows that the rest of the chip needs into a bank of 32-bit shadow words, so that system logic and software can read fuse-derived settings without touching the slow fuse array. It walks the array through a row-read port, one row per clock and always in ascending row order. Each row that belongs to a shadowed area is written into its slot. Scattered row ranges end up in contiguous groups of slots. When the walk finishes, a cache-done flag is raised.

A load starts by itself when reset is released. Software can start another load by writing the trigger address with bit 0 set. The same walk also refreshes three test-bit flags. Each flag reports whether the four test bits of row 0 in one array are all clear. The shadow slots cannot be written from the bus, and every load overwrites each slot completely.

Top module: `fuse_shadow_loader`

## Requirements
- R1: After reset is released a load begins without any trigger: `load_busy` is 1, the first fuse request (array 0, row 0) is on the port, `cache_done` is 0, and shadow slots and `tbit_ok` read 0.
- R2: A load issues exactly one request per cycle for 66 consecutive cycles: array 0 rows 0 to 63, then array 2 row 0, then array 3 row 0. Read data arrives one cycle after its request. `load_busy` stays 1 until the cycle after the last data has been written, which is 67 cycles after the start edge.
- R3: A bus write to address 63 with data bit 0 equal to 1 starts a load. The same write with bit 0 equal to 0 starts nothing. Reading address 63 returns 0.
- R4: `cache_done` goes to 0 at the edge that starts a load and goes to 1 at the edge that writes the last row. It then holds until the next start.
- R5: Slot 0 holds array 0 row 22 bit for bit, including the field in bits 25:11 and the lock and invalid fields in bits 31:26.
- R6: Slot 1 holds row 16 masked to bits 16:0 with bits 31:17 zero. Slot 2 holds row 20 and slot 3 holds row 21, both whole.
- R7: Slots 4 to 6 hold rows 3 to 5. Slot 7 holds row 6 and slot 8 holds row 17. Slots 9 to 16 hold rows 8 to 15 and slot 17 holds row 23. Slots 18 to 29 hold rows 40 to 51 and slots 30 to 41 hold rows 52 to 63.
- R8: Bus writes to addresses 0 to 62 change no slot. Reads of addresses 42 to 63 return 0.
- R9: `tbit_ok[0]`, `tbit_ok[1]` and `tbit_ok[2]` are 1 when bits 31:28 of row 0 are all zero in arrays 0, 2 and 3 respectively. They are updated by every load and otherwise hold.
- R10: A load overwrites each slot, so bits that are set in a slot but clear in the fuse row become 0.
- R11: A trigger is ignored while requests are still being issued. A trigger in the cycle where the final row is being written is accepted. In that case `cache_done` stays 0 and a new request sequence starts at array 0 row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_wr_addr | input | 6 | Bus write word address (63 = load trigger) |
| bus_wr_data | input | 32 | Bus write data |
| bus_rd_addr | input | 6 | Bus read word address |
| bus_rd_data | output | 32 | Shadow slot contents, 0 for unused addresses |
| fuse_rd_en | output | 1 | Fuse row read request |
| fuse_rd_arr | output | 2 | Requested array select |
| fuse_rd_row | output | 6 | Requested row |
| fuse_rd_data | input | 32 | Row data, valid the cycle after the request |
| load_busy | output | 1 | Load in progress |
| cache_done | output | 1 | Last completed load finished |
| tbit_ok | output | 3 | Test-bit check results for arrays 0, 2, 3 |

## Verification
Two functions can share an edge: the write of the final row, which sets `cache_done`, and the acceptance of a new trigger, which clears it. The bench provokes this by putting a trigger on the bus in the cycle after the last request. It checks that `cache_done` stays 0, that a fresh request for array 0 row 0 appears at once, and that the load which follows completes with correct slots. A second case places a trigger in the middle of the request sequence. There the bench checks that the row order is not disturbed.

// File: rtl/fsc_pkg.sv
`timescale 1ns/1ps
// Shared constants and row-to-slot mapping for the fuse shadow cache loader.
// Assumes a 32-bit fuse row and 64 rows per array.
package fsc_pkg;
    localparam int WORD_W     = 32;
    localparam int ROW_W      = 6;
    localparam int ARR_W      = 2;
    localparam int SLOT_W     = 6;
    localparam int SLOT_N     = 42;
    localparam int STEP_W     = 7;
    localparam int LOAD_STEPS = (1 << ROW_W) + 2;
    localparam int MISC_KEEP  = 17;
    localparam int TBIT_LSB   = 28;
    localparam int TBIT_W     = 4;
    localparam int TBIT_N     = 3;
    localparam logic [SLOT_W-1:0] TRIG_ADDR = SLOT_W'(63);

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } slot_sel_t;

    // Which shadow slot (if any) receives a given array/row.
    function automatic slot_sel_t row_slot(input logic [ARR_W-1:0] arr,
                                           input logic [ROW_W-1:0] row);
        slot_sel_t s;
        s.hit  = 1'b1;
        s.slot = '0;
        if (arr != '0)                                s.hit  = 1'b0;
        else if (row == 6'd22)                        s.slot = 6'd0;
        else if (row == 6'd16)                        s.slot = 6'd1;
        else if (row == 6'd20)                        s.slot = 6'd2;
        else if (row == 6'd21)                        s.slot = 6'd3;
        else if (row == 6'd17)                        s.slot = 6'd8;
        else if (row == 6'd23)                        s.slot = 6'd17;
        else if (row >= 6'd3 && row <= 6'd15 && row != 6'd7) s.slot = row + 6'd1;
        else if (row >= 6'd40)                        s.slot = row - 6'd22;
        else                                          s.hit  = 1'b0;
        return s;
    endfunction

    // Bits kept when a row is stored into a slot.
    function automatic logic [WORD_W-1:0] slot_keep(input logic [SLOT_W-1:0] slot);
        if (slot == 6'd1) return WORD_W'((64'd1 << MISC_KEEP) - 64'd1);
        return '1;
    endfunction
endpackage

// File: rtl/fsc_sequencer.sv
`timescale 1ns/1ps
// Walks the fuse array one row per clock: array 0 rows ascending, then
// row 0 of the two extra arrays. Data returns one cycle after a request;
// the write stage is the registered request. Starts itself out of reset.
module fsc_sequencer #(
    parameter int STEP_W     = fsc_pkg::STEP_W,
    parameter int ROW_W      = fsc_pkg::ROW_W,
    parameter int ARR_W      = fsc_pkg::ARR_W,
    parameter int LOAD_STEPS = fsc_pkg::LOAD_STEPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    output logic             launch,
    output logic             rd_en,
    output logic [ARR_W-1:0] rd_arr,
    output logic [ROW_W-1:0] rd_row,
    output logic             wr_en,
    output logic [ARR_W-1:0] wr_arr,
    output logic [ROW_W-1:0] wr_row,
    output logic             last_wr,
    output logic             busy
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(LOAD_STEPS - 1);
    localparam logic [STEP_W-1:0] ROWS = STEP_W'(1 << ROW_W);

    logic              run, pend, past_ok;
    logic [STEP_W-1:0] step, pend_step;

    function automatic logic [ARR_W+ROW_W-1:0] step_addr(input logic [STEP_W-1:0] s);
        logic [STEP_W-1:0] extra;
        extra = s - ROWS;
        if (s < ROWS) return {ARR_W'(0), s[ROW_W-1:0]};
        return {ARR_W'(extra + STEP_W'(2)), ROW_W'(0)};
    endfunction

    assign launch  = start_req && !run;
    assign rd_en   = run;
    assign {rd_arr, rd_row} = step_addr(step);
    assign wr_en   = pend;
    assign {wr_arr, wr_row} = step_addr(pend_step);
    assign last_wr = pend && (pend_step == LAST);
    assign busy    = run || pend;

    // Request counter and one-deep write stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b1;
            step      <= '0;
            pend      <= 1'b0;
            pend_step <= '0;
        end else begin
            pend      <= run;
            pend_step <= step;
            if (run) begin
                if (step == LAST) run <= 1'b0;
                step <= step + 1'b1;
            end else if (launch) begin
                run  <= 1'b1;
                step <= '0;
            end
        end
    end

    // Marks cycles whose $past values come from after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_row_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        (rd_en && $past(rd_en) && $past(rd_arr) == '0 && $past(rd_row) != '1)
        |-> (rd_arr == '0 && rd_row == $past(rd_row) + 1'b1));

    assert_write_follows_R2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        wr_en |-> ($past(rd_en) && wr_row == $past(rd_row) && wr_arr == $past(rd_arr)));
endmodule

// File: rtl/fsc_shadow_bank.sv
`timescale 1ns/1ps
// Shadow slot storage. Only the loader writes; each write replaces the
// whole slot under its keep mask. Reads are combinational.
module fsc_shadow_bank #(
    parameter int WORD_W = fsc_pkg::WORD_W,
    parameter int SLOT_W = fsc_pkg::SLOT_W,
    parameter int SLOT_N = fsc_pkg::SLOT_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] words [SLOT_N];
    logic              past_ok;

    for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
        localparam logic [SLOT_W-1:0] IDX  = SLOT_W'(g);
        localparam logic [WORD_W-1:0] KEEP = fsc_pkg::slot_keep(IDX);

        // Replace this slot when the loader targets it.
        always_ff @(posedge clk) begin
            if (!rst_n)                        words[g] <= '0;
            else if (wr_en && wr_slot == IDX)  words[g] <= wr_data & KEEP;
        end

        assert_slot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
            !$past(wr_en && wr_slot == IDX) |-> $stable(words[g]));
    end

    // Read mux; addresses past the last slot read zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr < SLOT_W'(SLOT_N)) rd_data = words[rd_addr];
    end

    // Marks cycles whose $past values come from after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end
endmodule

// File: rtl/fsc_tbit_flags.sv
`timescale 1ns/1ps
// Test-bit flags: one per checked array, set when the test nibble of
// row 0 is all zero. Updated only when the loader writes that row.
module fsc_tbit_flags #(
    parameter int ARR_W  = fsc_pkg::ARR_W,
    parameter int ROW_W  = fsc_pkg::ROW_W,
    parameter int TBIT_W = fsc_pkg::TBIT_W,
    parameter int TBIT_N = fsc_pkg::TBIT_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ARR_W-1:0]  wr_arr,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [TBIT_W-1:0] nibble,
    output logic [TBIT_N-1:0] ok
);
    localparam logic [ARR_W-1:0] SEL [3] = '{ARR_W'(0), ARR_W'(2), ARR_W'(3)};
    logic past_ok;

    for (genvar g = 0; g < TBIT_N; g++) begin : g_flag
        // Refresh this flag when row 0 of its array passes by.
        always_ff @(posedge clk) begin
            if (!rst_n) ok[g] <= 1'b0;
            else if (wr_en && wr_row == '0 && wr_arr == SEL[g]) ok[g] <= (nibble == '0);
        end
    end

    // Marks cycles whose $past values come from after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        !$past(wr_en) |-> $stable(ok));
endmodule

// File: rtl/fuse_shadow_loader.sv
`timescale 1ns/1ps
// Fuse shadow cache loader top. Decodes the bus trigger, routes loaded
// rows to slots and test-bit flags, and keeps the cache-done flag.
// Assumes the fuse port returns data one cycle after each request.
module fuse_shadow_loader (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr_en,
    input  logic [5:0]  bus_wr_addr,
    input  logic [31:0] bus_wr_data,
    input  logic [5:0]  bus_rd_addr,
    output logic [31:0] bus_rd_data,
    output logic        fuse_rd_en,
    output logic [1:0]  fuse_rd_arr,
    output logic [5:0]  fuse_rd_row,
    input  logic [31:0] fuse_rd_data,
    output logic        load_busy,
    output logic        cache_done,
    output logic [2:0]  tbit_ok
);
    import fsc_pkg::*;

    logic             trig, launch, wr_en, last_wr, past_ok;
    logic [ARR_W-1:0] wr_arr;
    logic [ROW_W-1:0] wr_row;
    slot_sel_t        sel;
    logic [30:0]      unused_wdata;

    assign trig         = bus_wr_en && bus_wr_addr == TRIG_ADDR && bus_wr_data[0];
    assign unused_wdata = bus_wr_data[31:1];
    assign sel          = row_slot(wr_arr, wr_row);

    fsc_sequencer i_seq (
        .clk(clk), .rst_n(rst_n), .start_req(trig), .launch(launch),
        .rd_en(fuse_rd_en), .rd_arr(fuse_rd_arr), .rd_row(fuse_rd_row),
        .wr_en(wr_en), .wr_arr(wr_arr), .wr_row(wr_row),
        .last_wr(last_wr), .busy(load_busy)
    );

    fsc_shadow_bank i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && sel.hit), .wr_slot(sel.slot),
        .wr_data(fuse_rd_data), .rd_addr(bus_rd_addr), .rd_data(bus_rd_data)
    );

    fsc_tbit_flags i_tbit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_arr(wr_arr), .wr_row(wr_row),
        .nibble(fuse_rd_data[TBIT_LSB +: TBIT_W]), .ok(tbit_ok)
    );

    // Cache-done: a new start wins over completion in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       cache_done <= 1'b0;
        else if (launch)  cache_done <= 1'b0;
        else if (last_wr) cache_done <= 1'b1;
    end

    // Marks cycles whose $past values come from after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_done_rise_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $rose(cache_done) |-> ($past(load_busy) && !load_busy));

    assert_done_fall_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        $fell(cache_done) |-> (load_busy && fuse_rd_en && fuse_rd_row == '0));

    assert_busy_done_R4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
        fuse_rd_en |-> !cache_done);
endmodule

// File: tb/test_fuse_shadow_loader.sv
`timescale 1ns/1ps
module test_fuse_shadow_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [5:0]  bus_wr_addr = '0;
    logic [31:0] bus_wr_data = '0;
    logic [5:0]  bus_rd_addr = '0;
    logic [31:0] bus_rd_data;
    logic        fuse_rd_en;
    logic [1:0]  fuse_rd_arr;
    logic [5:0]  fuse_rd_row;
    logic [31:0] fuse_rd_data = '0;
    logic        load_busy, cache_done;
    logic [2:0]  tbit_ok;

    logic [31:0] fuse_mem [4][64];
    int vec_n = 0;
    int miss_n = 0;

    always #2 clk = ~clk;

    fuse_shadow_loader i_fuse_shadow_loader (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr),
        .bus_wr_data(bus_wr_data), .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data),
        .fuse_rd_en(fuse_rd_en), .fuse_rd_arr(fuse_rd_arr), .fuse_rd_row(fuse_rd_row),
        .fuse_rd_data(fuse_rd_data), .load_busy(load_busy), .cache_done(cache_done),
        .tbit_ok(tbit_ok)
    );

    // Fuse array model: registered row read.
    always @(posedge clk) if (fuse_rd_en) fuse_rd_data <= fuse_mem[fuse_rd_arr][fuse_rd_row];

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        vec_n++;
        if (!ok) begin
            miss_n++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Expected slot contents, indexed by slot.
    function automatic logic [31:0] exp_slot(input int s);
        if (s == 0)              return fuse_mem[0][22];
        if (s == 1)              return fuse_mem[0][16] & 32'h0001_ffff;
        if (s == 2)              return fuse_mem[0][20];
        if (s == 3)              return fuse_mem[0][21];
        if (s >= 4 && s <= 7)    return fuse_mem[0][s-1];
        if (s == 8)              return fuse_mem[0][17];
        if (s >= 9 && s <= 16)   return fuse_mem[0][s-1];
        if (s == 17)             return fuse_mem[0][23];
        if (s >= 18 && s <= 41)  return fuse_mem[0][s+22];
        return 32'h0;
    endfunction

    function automatic logic [2:0] exp_tbit();
        return {fuse_mem[3][0][31:28] == 4'h0, fuse_mem[2][0][31:28] == 4'h0,
                fuse_mem[0][0][31:28] == 4'h0};
    endfunction

    task automatic fill_fuse();
        for (int a = 0; a < 4; a++)
            for (int r = 0; r < 64; r++) fuse_mem[a][r] = $urandom;
        if ($urandom % 2) fuse_mem[0][0][31:28] = 4'h0;
        if ($urandom % 2) fuse_mem[2][0][31:28] = 4'h0;
        if ($urandom % 2) fuse_mem[3][0][31:28] = 4'h0;
    endtask

    // Called at a negedge; leaves at the negedge of the cycle after the start edge.
    task automatic trigger();
        bus_wr_en = 1'b1; bus_wr_addr = 6'd63; bus_wr_data = $urandom | 32'h1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic verify_contents(input string tag);
        for (int a = 0; a < 64; a++) begin
            bus_rd_addr = 6'(a);
            #0.5;
            if (tag != "")       chk(bus_rd_data === exp_slot(a), tag, bus_rd_data, exp_slot(a));
            else if (a == 0)     chk(bus_rd_data === exp_slot(a), "R5", bus_rd_data, exp_slot(a));
            else if (a <= 3)     chk(bus_rd_data === exp_slot(a), "R6", bus_rd_data, exp_slot(a));
            else if (a <= 41)    chk(bus_rd_data === exp_slot(a), "R7", bus_rd_data, exp_slot(a));
            else                 chk(bus_rd_data === 32'h0, "R8 R3 unused read", bus_rd_data, 32'h0);
        end
        chk(tbit_ok === exp_tbit(), "R9", 32'(tbit_ok), 32'(exp_tbit()));
        @(negedge clk);
    endtask

    // Entered at the negedge of the cycle after a start edge.
    task automatic run_load_check(input int poke_k, input bit chain);
        logic [1:0] ea;
        logic [5:0] er;
        chk(load_busy === 1'b1 && cache_done === 1'b0, "R4 start", {30'h0, load_busy, cache_done}, 32'h2);
        for (int k = 0; k < 66; k++) begin
            ea = (k < 64) ? 2'd0 : ((k == 64) ? 2'd2 : 2'd3);
            er = (k < 64) ? 6'(k) : 6'd0;
            chk(fuse_rd_en === 1'b1 && fuse_rd_arr === ea && fuse_rd_row === er, "R2 R11 order",
                {23'h0, fuse_rd_en, fuse_rd_arr, fuse_rd_row}, {23'h0, 1'b1, ea, er});
            if (k == poke_k) begin
                bus_wr_en = 1'b1; bus_wr_addr = 6'd63; bus_wr_data = 32'h1;
            end else begin
                bus_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        bus_wr_en = 1'b0;
        chk(load_busy === 1'b1 && fuse_rd_en === 1'b0 && cache_done === 1'b0, "R2 tail",
            {29'h0, load_busy, fuse_rd_en, cache_done}, 32'h4);
        if (chain) begin
            trigger();
            chk(cache_done === 1'b0 && load_busy === 1'b1 && fuse_rd_en === 1'b1 && fuse_rd_row === 6'd0,
                "R11 coincide", {29'h0, cache_done, load_busy, fuse_rd_en}, 32'h3);
        end else begin
            @(negedge clk);
            chk(load_busy === 1'b0 && cache_done === 1'b1, "R2 R4 end",
                {30'h0, load_busy, cache_done}, 32'h1);
        end
    endtask

    initial begin
        void'($urandom(32'd7411));
        fill_fuse();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, load already running.
        chk(load_busy === 1'b1 && fuse_rd_en === 1'b1 && fuse_rd_row === 6'd0 && fuse_rd_arr === 2'd0,
            "R1 autostart", {30'h0, load_busy, fuse_rd_en}, 32'h3);
        chk(cache_done === 1'b0 && tbit_ok === 3'b000, "R1 flags", {28'h0, cache_done, tbit_ok}, 32'h0);
        chk(bus_rd_data === 32'h0, "R1 slot0", bus_rd_data, 32'h0);
        run_load_check(-1, 1'b0);
        verify_contents("");

        // R8: bus writes to slot addresses have no effect; R3: bit0=0 trigger ignored.
        for (int i = 0; i < 20; i++) begin
            bus_wr_en = 1'b1; bus_wr_addr = 6'($urandom % 63); bus_wr_data = $urandom;
            @(negedge clk);
        end
        bus_wr_en = 1'b1; bus_wr_addr = 6'd63; bus_wr_data = $urandom & 32'hffff_fffe;
        @(negedge clk);
        bus_wr_en = 1'b0;
        chk(load_busy === 1'b0 && fuse_rd_en === 1'b0 && cache_done === 1'b1, "R3 bit0 clear",
            {29'h0, load_busy, fuse_rd_en, cache_done}, 32'h1);
        verify_contents("R8 write ignored");

        // Random contents with software-triggered loads; one with a mid-walk trigger (R11).
        for (int it = 0; it < 4; it++) begin
            fill_fuse();
            trigger();
            run_load_check((it == 1) ? 20 : -1, 1'b0);
            verify_contents("");
        end

        // R10: slot must drop bits that are no longer set.
        fuse_mem[0][22] = 32'hffff_ffff; fuse_mem[0][16] = 32'hffff_ffff;
        trigger(); run_load_check(-1, 1'b0); verify_contents("R10 ones");
        fuse_mem[0][22] = 32'h0; fuse_mem[0][16] = 32'h0;
        fuse_mem[0][0] = 32'hf000_0000; fuse_mem[2][0] = 32'h0; fuse_mem[3][0] = 32'h1000_0000;
        trigger(); run_load_check(-1, 1'b0); verify_contents("R10 zeros");

        // R11: trigger in the completing cycle.
        fill_fuse();
        trigger();
        run_load_check(-1, 1'b1);
        run_load_check(-1, 1'b0);
        verify_contents("");

        $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miss_n++;
        $display("FAIL watchdog got=hung exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
        $finish;
    end
endmodule